// File: doc/BRIEF.md
# Registered Command Buffer with Chip-Select Modes

This block is the register stage that sits between a memory controller and the devices on a memory module. On every rising clock edge it captures the address and command bus and drives it out again as two identical copies, so that each half of the module gets its own copy. A small control group carries two clock-enable bits and two on-die-termination bits. It is captured one-to-one.

The chip-select inputs are active low. A static strap chooses how they reach the outputs. With the strap high there are two chip-select inputs, and each one is copied to both output banks. With the strap low there are four chip-select inputs, and each drives its own output. When no chip select is active in a capturing cycle, the address and command outputs keep their previous value, which saves switching power. The control group is not gated in this way.

A synchronous, active-high reset forces every output to a known state. The strap is loaded only while reset is held.

Top module: `cmdbuf_top`

## Requirements
- R1: When at least one counted chip-select input is low at a rising edge, `cmd_i` appears on `cmd_a_o` after that edge, with one cycle of latency.
- R2: `cmd_b_o` always carries the same value as `cmd_a_o`.
- R3: In two-select mode (strap latched high), `cs_n_i[0]` is registered to `cs_n_o[0]` and `cs_n_o[2]`, and `cs_n_i[1]` is registered to `cs_n_o[1]` and `cs_n_o[3]`. `cs_n_i[3:2]` are ignored.
- R4: In four-select mode (strap latched low), `cs_n_i[i]` is registered to `cs_n_o[i]` for i = 0..3.
- R5: When every counted chip-select input is high at an edge, `cmd_a_o` and `cmd_b_o` hold their value. In two-select mode only `cs_n_i[1:0]` are counted, so a low on `cs_n_i[3:2]` does not cause a capture.
- R6: `cke_i` and `odt_i` are registered to `cke_o` and `odt_o` on every edge, whatever the chip selects are doing.
- R7: A rising edge with `rst` high drives `cs_n_o` to all ones, and `cke_o`, `odt_o`, `cmd_a_o` and `cmd_b_o` to zero.
- R8: The mode is taken from `cs_strap_i` only at edges where `rst` is high. A change of the strap outside reset has no effect on the chip-select mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_strap_i | input | 1 | Mode strap: 1 = two selects duplicated, 0 = four direct |
| cs_n_i | input | 4 | Chip-select inputs, active low |
| cmd_i | input | CMD_W | Address and command bus |
| cke_i | input | 2 | Clock-enable inputs |
| odt_i | input | 2 | On-die-termination inputs |
| cs_n_o | output | 4 | Registered chip-select outputs, active low |
| cmd_a_o | output | CMD_W | Registered command copy A |
| cmd_b_o | output | CMD_W | Registered command copy B |
| cke_o | output | 2 | Registered clock-enable outputs |
| odt_o | output | 2 | Registered on-die-termination outputs |

## Verification
Random chip-select patterns are run in both modes. Some cycles force all selects high and others pull low only the upper pair, which separates a true idle hold from a capture and shows whether the upper inputs are counted in two-select mode. Random control bits are driven during idle stretches, which shows that clock enable and termination ignore the gating. The strap is toggled outside reset to tell a latched mode from a live one. A reset in the middle of the run, with nonzero outputs, shows that the reset values are forced rather than left over from start-up.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int CS_W  = 4;
    localparam int CKE_W = 2;
    localparam int ODT_W = 2;

    typedef enum logic {
        CS_MODE_QUAD = 1'b0,
        CS_MODE_DUAL = 1'b1
    } cs_mode_e;

    typedef struct packed {
        logic [CKE_W-1:0] cke;
        logic [ODT_W-1:0] odt;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{cke: '0, odt: '0};

    // Route chip-select inputs to the four output slots.
    function automatic logic [CS_W-1:0] cs_route(cs_mode_e m, logic [CS_W-1:0] cs_n);
        logic [CS_W-1:0] r;
        if (m == CS_MODE_DUAL) r = {cs_n[1], cs_n[0], cs_n[1], cs_n[0]};
        else                   r = cs_n;
        return r;
    endfunction

    // True when any counted select is asserted (low).
    function automatic logic cs_any(cs_mode_e m, logic [CS_W-1:0] cs_n);
        logic a;
        if (m == CS_MODE_DUAL) a = ~&cs_n[1:0];
        else                   a = ~&cs_n;
        return a;
    endfunction

endpackage

// File: rtl/cmdbuf_mode.sv
module cmdbuf_mode
    import cmdbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strap_i,
    output cs_mode_e mode_o
);

    cs_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= cs_mode_e'(strap_i);
    end

    assign mode_o = mode_q;

    p_mode_static_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q))
        else $error("mode changed outside reset");

endmodule

// File: rtl/cmdbuf_cs_stage.sv
module cmdbuf_cs_stage
    import cmdbuf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cs_mode_e        mode_i,
    input  logic [CS_W-1:0] cs_n_i,
    output logic [CS_W-1:0] cs_n_o,
    output logic            capture_o
);

    logic [CS_W-1:0] cs_q;
    logic [CS_W-1:0] cs_next;

    always_comb begin
        cs_next   = cs_route(mode_i, cs_n_i);
        capture_o = cs_any(mode_i, cs_n_i);
    end

    always_ff @(posedge clk) begin
        if (rst) cs_q <= '1;
        else     cs_q <= cs_next;
    end

    assign cs_n_o = cs_q;

    p_dual_dup_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CS_MODE_DUAL) |=> (cs_q[1:0] == cs_q[3:2]) && (cs_q[1:0] == $past(cs_n_i[1:0])))
        else $error("two-select duplication broken");

    p_quad_direct_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CS_MODE_QUAD) |=> cs_q == $past(cs_n_i))
        else $error("four-select mapping broken");

endmodule

// File: rtl/cmdbuf_data_stage.sv
module cmdbuf_data_stage
    import cmdbuf_pkg::*;
#(
    parameter int CMD_W = 22,
    parameter int NCOPY = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        capture_i,
    input  logic [CMD_W-1:0]            cmd_i,
    input  ctl_t                        ctl_i,
    output logic [NCOPY-1:0][CMD_W-1:0] cmd_o,
    output ctl_t                        ctl_o
);

    ctl_t ctl_q;

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        logic [CMD_W-1:0] cmd_q;
        always_ff @(posedge clk) begin
            if (rst)            cmd_q <= '0;
            else if (capture_i) cmd_q <= cmd_i;
        end
        assign cmd_o[c] = cmd_q;

        p_capture_r1: assert property (@(posedge clk) disable iff (rst)
            capture_i |=> cmd_q == $past(cmd_i))
            else $error("command not captured");

        p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
            !capture_i |=> $stable(cmd_q))
            else $error("command changed while idle");
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_i;
    end

    assign ctl_o = ctl_q;

    p_ctl_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ctl_q == $past(ctl_i))
        else $error("control group not registered");

    p_copy_match_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cmd_o[0] == cmd_o[NCOPY-1])
        else $error("copies diverged");

endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
    import cmdbuf_pkg::*;
#(
    parameter int CMD_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_strap_i,
    input  logic [3:0]       cs_n_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [1:0]       cke_i,
    input  logic [1:0]       odt_i,
    output logic [3:0]       cs_n_o,
    output logic [CMD_W-1:0] cmd_a_o,
    output logic [CMD_W-1:0] cmd_b_o,
    output logic [1:0]       cke_o,
    output logic [1:0]       odt_o
);

    localparam int NCOPY = 2;

    cs_mode_e                   mode;
    logic                       capture;
    ctl_t                       ctl_in;
    ctl_t                       ctl_out;
    logic [NCOPY-1:0][CMD_W-1:0] cmd_copies;

    assign ctl_in = '{cke: cke_i, odt: odt_i};

    cmdbuf_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .strap_i (cs_strap_i),
        .mode_o  (mode)
    );

    cmdbuf_cs_stage u_cs (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .cs_n_i    (cs_n_i),
        .cs_n_o    (cs_n_o),
        .capture_o (capture)
    );

    cmdbuf_data_stage #(.CMD_W(CMD_W), .NCOPY(NCOPY)) u_data (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .cmd_i     (cmd_i),
        .ctl_i     (ctl_in),
        .cmd_o     (cmd_copies),
        .ctl_o     (ctl_out)
    );

    assign cmd_a_o = cmd_copies[0];
    assign cmd_b_o = cmd_copies[1];
    assign cke_o   = ctl_out.cke;
    assign odt_o   = ctl_out.odt;

endmodule

// File: tb/sim_cmdbuf_top.sv
`timescale 1ns/1ps
module sim_cmdbuf_top;

    localparam int CMD_W = 22;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_strap_i = 1'b1;
    logic [3:0]       cs_n_i = 4'hF;
    logic [CMD_W-1:0] cmd_i = '0;
    logic [1:0]       cke_i = '0;
    logic [1:0]       odt_i = '0;
    logic [3:0]       cs_n_o;
    logic [CMD_W-1:0] cmd_a_o, cmd_b_o;
    logic [1:0]       cke_o, odt_o;

    int checks = 0;
    int fails  = 0;

    // model state
    logic             m_mode = 1'b1;
    logic             m_rst  = 1'b1;
    logic             m_cap  = 1'b0;
    logic [3:0]       e_cs   = 4'hF;
    logic [CMD_W-1:0] e_cmd  = '0;
    logic [1:0]       e_cke  = '0, e_odt = '0;

    always #2.5 clk = ~clk;

    cmdbuf_top #(.CMD_W(CMD_W)) u0 (
        .clk(clk), .rst(rst), .cs_strap_i(cs_strap_i), .cs_n_i(cs_n_i),
        .cmd_i(cmd_i), .cke_i(cke_i), .odt_i(odt_i), .cs_n_o(cs_n_o),
        .cmd_a_o(cmd_a_o), .cmd_b_o(cmd_b_o), .cke_o(cke_o), .odt_o(odt_o)
    );

    function automatic logic [3:0] exp_route(logic mode, logic [3:0] cs);
        if (mode) return {cs[1], cs[0], cs[1], cs[0]};
        return cs;
    endfunction

    function automatic logic exp_any(logic mode, logic [3:0] cs);
        if (mode) return (cs[0] == 1'b0) || (cs[1] == 1'b0);
        return cs != 4'hF;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: update model at the edge, compare at the following falling edge
    task automatic cycle();
        @(posedge clk);
        m_rst = rst;
        if (rst) begin
            m_mode = cs_strap_i;
            e_cs = 4'hF; e_cmd = '0; e_cke = '0; e_odt = '0; m_cap = 1'b0;
        end else begin
            e_cs  = exp_route(m_mode, cs_n_i);
            m_cap = exp_any(m_mode, cs_n_i);
            if (m_cap) e_cmd = cmd_i;
            e_cke = cke_i; e_odt = odt_i;
        end
        @(negedge clk);
        if (m_rst) begin
            check("R7 cs", 64'(cs_n_o), 64'(e_cs));
            check("R7 cmd", 64'(cmd_a_o), 64'(e_cmd));
            check("R7 cmdb", 64'(cmd_b_o), 64'(e_cmd));
            check("R7 ctl", 64'({cke_o, odt_o}), 64'({e_cke, e_odt}));
        end else begin
            if (cs_strap_i != m_mode) check("R8 cs", 64'(cs_n_o), 64'(e_cs));
            else if (m_mode)          check("R3 cs", 64'(cs_n_o), 64'(e_cs));
            else                      check("R4 cs", 64'(cs_n_o), 64'(e_cs));
            if (m_cap) check("R1 cmd", 64'(cmd_a_o), 64'(e_cmd));
            else       check("R5 cmd", 64'(cmd_a_o), 64'(e_cmd));
            check("R2 copy", 64'(cmd_b_o), 64'(e_cmd));
            check("R6 ctl", 64'({cke_o, odt_o}), 64'({e_cke, e_odt}));
        end
    endtask

    task automatic drive_rand(int idle_pct);
        cmd_i = CMD_W'($urandom);
        cke_i = 2'($urandom);
        odt_i = 2'($urandom);
        if (($urandom % 100) < idle_pct) cs_n_i = 4'hF;
        else                             cs_n_i = 4'($urandom);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired (R1) actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // reset in two-select mode (R7)
        rst = 1'b1; cs_strap_i = 1'b1;
        for (int i = 0; i < 3; i++) cycle();
        rst = 1'b0;
        // random traffic in two-select mode (R1 R2 R3 R5 R6)
        for (int i = 0; i < 300; i++) begin drive_rand(25); cycle(); end
        // directed: only upper selects low -> no capture in two-select mode (R5)
        cmd_i = CMD_W'(22'h2AAAAA); cs_n_i = 4'b0011; cke_i = 2'b11; odt_i = 2'b10; cycle();
        cmd_i = CMD_W'(22'h155555); cs_n_i = 4'b1110; cycle();
        cs_n_i = 4'hF; cmd_i = '0; cycle();
        // strap flipped outside reset must be ignored (R8)
        cs_strap_i = 1'b0;
        for (int i = 0; i < 60; i++) begin drive_rand(20); cycle(); end
        cs_n_i = 4'b0111; cmd_i = CMD_W'(22'h0F0F0F); cycle();
        // reset mid-run with nonzero outputs, latch four-select mode (R7)
        cs_n_i = 4'b0000; cmd_i = '1; cke_i = 2'b11; odt_i = 2'b11; cycle();
        rst = 1'b1; cycle(); cycle();
        rst = 1'b0;
        // random traffic in four-select mode (R4)
        for (int i = 0; i < 300; i++) begin drive_rand(25); cycle(); end
        // directed: single upper select low captures in four-select mode (R4 R1)
        cs_n_i = 4'b0111; cmd_i = CMD_W'(22'h3C3C3C); cycle();
        // all high holds; control still moves (R5 R6)
        cs_n_i = 4'hF; cmd_i = CMD_W'(22'h000111); cke_i = 2'b01; odt_i = 2'b10; cycle();
        cke_i = 2'b10; odt_i = 2'b01; cycle();
        // strap back high without reset ignored (R8)
        cs_strap_i = 1'b1;
        for (int i = 0; i < 40; i++) begin drive_rand(30); cycle(); end
        finish_run();
    end

endmodule